// File: doc/BRIEF.md
# Pipelined XOR Register-File Datapath

This block is a small datapath built around a register file. Each cycle it takes one instruction: two source selects, a destination select and a stall flag. The two source registers are read into operand registers. Their bitwise XOR is formed in the next cycle and then passes down a chain of pipeline registers whose length is set by a parameter. At the end of the chain the result is written into the destination register.

A stalled instruction still moves down the pipe in step with the others, but it arrives with its valid bit clear and writes nothing. Source reads never take results that are still in flight. A combinational inspection port returns any register of the file.

Top module: `xor_pipe_rf`

## Requirements
- R1: A synchronous reset loads register i with ((i+1)*INIT_STEP) modulo 2^DATA_W and clears every in-flight valid bit, so an instruction issued before reset never writes. With the defaults the registers hold 0x35, 0x6A, 0x9F and 0xD4.
- R2: A valid instruction writes the XOR of the two source registers into the destination register. Equal source selects write zero.
- R3: An instruction is sampled at a clock edge, counted as edge 1. Its destination register keeps its old value through edge STAGES+1 and takes the result at edge STAGES+2.
- R4: An instruction issued with stall high changes no register.
- R5: An instruction never changes a register other than its destination.
- R6: Sources read the register file as it stood just before the sampling edge. A result that has not yet been written back is not forwarded.
- R7: The peek port returns the current contents of the selected register in the same cycle, with no clock delay.
- R8: One instruction is accepted per cycle and results land in issue order, so the later of two writes to the same register wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_a_sel | input | SEL_W | First source register select |
| src_b_sel | input | SEL_W | Second source register select |
| dst_sel | input | SEL_W | Destination register select |
| stall | input | 1 | Marks the instruction of this cycle as invalid |
| peek_sel | input | SEL_W | Register select for inspection |
| peek_data | output | DATA_W | Contents of the selected register |

## Verification
The bench builds the block with STAGES=2, DATA_W=8 and NREG=4. With a pipe deeper than one stage, a pass-through register sits between the first pipe stage and write-back. The exact write-back edge therefore differs from the read edge by more than one clock, so an off-by-one in the chain shows up. Dependent instructions issued back to back fall inside the in-flight window, and reset can cut off instructions that sit in every stage at once.

// File: rtl/xor_pipe_rf.sv
module xor_pipe_rf #(
  parameter int DATA_W    = 8,
  parameter int NREG      = 4,
  parameter int STAGES    = 1,
  parameter int INIT_STEP = 'h35,
  localparam int SEL_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  src_a_sel,
  input  logic [SEL_W-1:0]  src_b_sel,
  input  logic [SEL_W-1:0]  dst_sel,
  input  logic              stall,
  input  logic [SEL_W-1:0]  peek_sel,
  output logic [DATA_W-1:0] peek_data
);
  localparam int LAST = STAGES - 1;

  logic [NREG-1:0][DATA_W-1:0]   rf;
  logic [DATA_W-1:0]             opa, opb;
  logic [SEL_W-1:0]              op_dst;
  logic                          op_vld;
  logic [STAGES-1:0][DATA_W-1:0] p_dat;
  logic [STAGES-1:0][SEL_W-1:0]  p_dst;
  logic [STAGES-1:0]             p_vld;
  logic                          wb_en;

  function automatic logic [DATA_W-1:0] seed(input int idx);
    return DATA_W'((idx + 1) * INIT_STEP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      opa    <= '0;
      opb    <= '0;
      op_dst <= '0;
      op_vld <= 1'b0;
    end else begin
      opa    <= rf[src_a_sel];
      opb    <= rf[src_b_sel];
      op_dst <= dst_sel;
      op_vld <= !stall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_dat[0] <= '0;
      p_dst[0] <= '0;
      p_vld[0] <= 1'b0;
    end else begin
      p_dat[0] <= opa ^ opb;
      p_dst[0] <= op_dst;
      p_vld[0] <= op_vld;
    end
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_pass
    always_ff @(posedge clk) begin
      if (rst) begin
        p_dat[k] <= '0;
        p_dst[k] <= '0;
        p_vld[k] <= 1'b0;
      end else begin
        p_dat[k] <= p_dat[k-1];
        p_dst[k] <= p_dst[k-1];
        p_vld[k] <= p_vld[k-1];
      end
    end

    assert_pass_through_R3: assert property (@(posedge clk) disable iff (rst)
      p_vld[k-1] |=> p_vld[k] && p_dat[k] == $past(p_dat[k-1]));
  end

  assign wb_en = p_vld[LAST];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        rf[i] <= seed(i);
      else if (wb_en && p_dst[LAST] == SEL_W'(i))
        rf[i] <= p_dat[LAST];
    end
  end

  assign peek_data = rf[peek_sel];

  assert_writeback_value_R2: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> rf[$past(p_dst[LAST])] == $past(p_dat[LAST]));

  assert_invalid_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    !wb_en |=> $stable(rf));

  for (genvar i = 0; i < NREG; i++) begin : g_keep
    assert_other_regs_kept_R5: assert property (@(posedge clk) disable iff (rst)
      (wb_en && p_dst[LAST] != SEL_W'(i)) |=> $stable(rf[i]));
  end
endmodule

// File: tb/tb_xor_pipe_rf.sv
module tb_xor_pipe_rf;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 2;
  localparam int NREG = 4;
  localparam int DW = 8;
  localparam int D = STAGES + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] src_a_sel = '0, src_b_sel = '0, dst_sel = '0, peek_sel = '0;
  logic stall = 1'b1;
  logic [DW-1:0] peek_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] mrf [NREG];
  logic [DW-1:0] mdat [D];
  logic [1:0]    mdst [D];
  logic          mvld [D];

  xor_pipe_rf #(.DATA_W(DW), .NREG(NREG), .STAGES(STAGES), .INIT_STEP('h35)) dut (
    .clk(clk), .rst(rst), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
    .dst_sel(dst_sel), .stall(stall), .peek_sel(peek_sel), .peek_data(peek_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] seed(input int i);
    return DW'((i + 1) * 'h35);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mrf[i] = seed(i);
      for (int k = 0; k < D; k++) begin mvld[k] = 1'b0; mdat[k] = '0; mdst[k] = '0; end
    end else begin
      logic [DW-1:0] nv;
      nv = mrf[src_a_sel] ^ mrf[src_b_sel];
      if (mvld[D-1]) mrf[mdst[D-1]] = mdat[D-1];
      for (int k = D-1; k > 0; k--) begin
        mvld[k] = mvld[k-1]; mdat[k] = mdat[k-1]; mdst[k] = mdst[k-1];
      end
      mvld[0] = !stall; mdat[0] = nv; mdst[0] = dst_sel;
    end
  end

  task automatic check_val(input string req, input int idx, input logic [DW-1:0] exp);
    peek_sel = 2'(idx);
    #1;
    n_chk++;
    if (peek_data !== exp) begin
      n_bad++;
      $display("FAIL %s reg%0d actual=%h expected=%h", req, idx, peek_data, exp);
    end
  endtask

  task automatic check_model(input string req);
    @(negedge clk);
    for (int i = 0; i < NREG; i++) check_val(req, i, mrf[i]);
  endtask

  task automatic issue(input int a, input int b, input int d, input logic st);
    @(negedge clk);
    src_a_sel = 2'(a); src_b_sel = 2'(b); dst_sel = 2'(d); stall = st;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    stall = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stall = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check_val("R1", 0, 8'h35);
    check_val("R1", 1, 8'h6A);
    check_val("R1", 2, 8'h9F);
    check_val("R1", 3, 8'hD4);
  endtask

  task automatic t_latency();
    do_reset();
    issue(0, 1, 2, 1'b0);
    @(negedge clk);
    stall = 1'b1;
    check_val("R3", 2, 8'h9F);
    @(negedge clk);
    check_val("R3", 2, 8'h9F);
    @(negedge clk);
    check_val("R3", 2, 8'h9F);
    @(negedge clk);
    check_val("R3", 2, 8'h5F);
    check_val("R7", 0, 8'h35);
    check_val("R5", 1, 8'h6A);
    check_val("R5", 3, 8'hD4);
  endtask

  task automatic t_stall();
    do_reset();
    issue(0, 2, 3, 1'b1);
    issue(1, 1, 0, 1'b1);
    idle(6);
    check_val("R4", 3, 8'hD4);
    check_val("R4", 0, 8'h35);
    check_model("R4");
  endtask

  task automatic t_same_src();
    do_reset();
    issue(3, 3, 1, 1'b0);
    idle(5);
    check_val("R2", 1, 8'h00);
    check_model("R2");
  endtask

  task automatic t_no_bypass();
    do_reset();
    issue(1, 2, 0, 1'b0);
    issue(0, 3, 1, 1'b0);
    idle(6);
    check_val("R6", 0, 8'hF5);
    check_val("R6", 1, 8'hE1);
    check_model("R6");
  endtask

  task automatic t_stream();
    do_reset();
    issue(0, 1, 3, 1'b0);
    issue(2, 3, 3, 1'b0);
    issue(1, 0, 2, 1'b1);
    issue(3, 2, 0, 1'b0);
    issue(0, 0, 1, 1'b0);
    issue(1, 3, 2, 1'b0);
    issue(2, 1, 0, 1'b0);
    issue(3, 0, 3, 1'b0);
    idle(6);
    check_model("R8");
    for (int n = 0; n < 12; n++) issue((n * 3) % 4, (n + 1) % 4, (n * 5 + 2) % 4, (n % 5) == 3);
    idle(6);
    check_model("R8");
  endtask

  task automatic t_reset_mid();
    do_reset();
    issue(0, 1, 0, 1'b0);
    issue(2, 3, 1, 1'b0);
    issue(1, 2, 2, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; stall = 1'b1;
    idle(5);
    check_val("R1", 0, 8'h35);
    check_val("R1", 1, 8'h6A);
    check_val("R1", 2, 8'h9F);
    check_model("R1");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_stall();
    t_same_src();
    t_no_bypass();
    t_stream();
    t_reset_mid();
    summary();
    $finish;
  end
endmodule